// File: doc/BRIEF.md
# Acknowledged-Read Sequencer for a Multiplexed Peripheral Bus

This block runs read cycles on an external peripheral bus that carries address and data on one shared set of lines. It is clocked by the bus clock. A one-cycle `start` pulse launches a read. The sequencer drives the address with an address-latch strobe and then asserts the active-low select. It releases the shared lines and asserts the active-low read strobe. After a programmed hold period it watches the peripheral's acknowledge input. Once the acknowledge is recognised and a programmed settle delay has passed, it captures the read data and drops the read strobe. It then releases select after a programmed lag and rests for a programmed number of idle cycles before it accepts the next request.

The acknowledge is normally treated as asynchronous and passes through a two-stage synchronizer. A configuration bit lets a peripheral that meets setup and hold to the bus clock skip that synchronizer. Another bit selects which level counts as "acknowledged". An 8-bit wait limit aborts a read that is never acknowledged. The abort ends the cycle, returns zero data marked with an error, pulses an interrupt and sets a sticky timeout flag that a write-one-to-clear input resets.

The states are IDLE, LATCH, LATCH_GAP, SEL_LEAD, SEL_HOLD, ACK_WAIT, SETTLE, RELEASE and REST:

- IDLE goes to LATCH on `start`.
- Each timed state advances when its interval has run out: LATCH goes to LATCH_GAP, LATCH_GAP to SEL_LEAD, SEL_LEAD to SEL_HOLD, and SEL_HOLD to ACK_WAIT.
- ACK_WAIT leaves on recognition. It goes to SETTLE if the settle delay is non-zero; otherwise it captures the data at once and continues like the end of SETTLE.
- ACK_WAIT also leaves on timeout. It aborts and continues like the end of SETTLE.
- The end of SETTLE (the capture, or the abort) leads to RELEASE if the lag is non-zero, else to REST, else to IDLE.
- RELEASE goes to REST, or to IDLE when the rest length is zero.
- REST goes to IDLE.

All configuration inputs and the address are sampled when `start` is accepted.

Top module: `pbus_ackrd_ctrl`

## Requirements
- R1: After reset `pb_ale`=0, `pb_sel_n`=1, `pb_rd_n`=1, `pb_ad_drive`=0, and `busy`, `done`, `err_irq` and `tmo_flag` are all 0.
- R2: `start` is accepted in IDLE at a clock edge. From the cycle after that edge, `pb_ale` is high for `cfg_latch_len`+1 cycles. During those cycles `pb_ad_drive`=1 and `pb_ad_out` equals `addr`. `pb_ale` is then low for `cfg_latch_gap`+1 cycles before `pb_sel_n` goes low.
- R3: `pb_rd_n` goes low `cfg_sel_lead`+1 cycles after `pb_sel_n` goes low. `pb_ad_drive` is never 1 while `pb_rd_n` is 0.
- R4: The acknowledge is ignored until `pb_rd_n` has been low for `cfg_sel_hold`+1 cycles. An acknowledge present before then is recognised at the first edge of ACK_WAIT and does not end the read earlier.
- R5: With `cfg_ack_direct`=1, an acknowledge level present at an edge in ACK_WAIT is recognised at that edge. With `cfg_ack_direct`=0, the level passes two flip-flops and is recognised two edges later.
- R6: The acknowledge counts as asserted when `pb_ack` equals `cfg_ack_level` (1 = active high, 0 = active low).
- R7: `pb_ad_in` is captured at the edge that lies `cfg_ack_delay` cycles after the recognising edge, while `pb_rd_n` is still low. `done` is high for exactly one cycle after that edge, with `rd_data` = the captured value and `rd_err`=0. `pb_rd_n` returns high in that same cycle.
- R8: `pb_sel_n` returns high `cfg_release_lag` cycles (0 to 3) after `pb_rd_n` returns high.
- R9: `busy` is high from the cycle after `start` is accepted until `cfg_rest_len` cycles after `pb_sel_n` returns high. A `start` pulse while `busy` is high is ignored.
- R10: With `cfg_wait_limit`=L>0, the read is aborted if no acknowledge is recognised in the first L cycles of ACK_WAIT. Recognition in the L-th cycle still succeeds. On abort, in the cycle after the L-th one: `done`=1, `rd_err`=1, `rd_data`=0, `err_irq`=1 for that one cycle, `pb_rd_n` returns high, and `tmo_flag` becomes 1.
- R11: `cfg_wait_limit`=0 disables the timeout: a read waits indefinitely for the acknowledge.
- R12: `tmo_flag` stays 1 until `tmo_flag_clr` is high at a clock edge, which clears it; a new timeout in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start | input | 1 | one-cycle read request |
| addr | input | 32 | read address |
| cfg_latch_len | input | 4 | address-latch strobe length minus one |
| cfg_latch_gap | input | 4 | strobe-low gap before select, minus one |
| cfg_sel_lead | input | 4 | select-to-read-strobe delay minus one |
| cfg_sel_hold | input | 4 | acknowledge-ignore period after read strobe, minus one |
| cfg_ack_delay | input | 4 | cycles from recognition to capture |
| cfg_release_lag | input | 2 | cycles from read-strobe release to select release |
| cfg_rest_len | input | 4 | idle cycles after select release |
| cfg_ack_level | input | 1 | active level of the acknowledge |
| cfg_ack_direct | input | 1 | 1 = bypass the acknowledge synchronizer |
| cfg_wait_limit | input | 8 | acknowledge wait limit in cycles, 0 = none |
| pb_ale | output | 1 | address-latch strobe |
| pb_sel_n | output | 1 | active-low select |
| pb_rd_n | output | 1 | active-low read strobe |
| pb_ad_out | output | 32 | address driven onto shared lines |
| pb_ad_drive | output | 1 | enable of the shared-line driver |
| pb_ad_in | input | 32 | data read from shared lines |
| pb_ack | input | 1 | acknowledge from peripheral |
| busy | output | 1 | cycle in progress |
| done | output | 1 | one-cycle completion pulse |
| rd_data | output | 32 | read data, valid with done |
| rd_err | output | 1 | bus error flag, valid with done |
| err_irq | output | 1 | one-cycle timeout interrupt |
| tmo_flag | output | 1 | sticky timeout status |
| tmo_flag_clr | input | 1 | write-one-to-clear for tmo_flag |

## Verification
The bench drives the acknowledge at exact edges, so it can measure recognition latency with and without the synchronizer and under both polarities. A design with the wrong stage count or an inverted level completes early, late or never. It asserts the acknowledge during the hold period to catch a sequencer that looks at the acknowledge too soon. It places the acknowledge in the last allowed wait cycle and then one cycle too late, which exposes an off-by-one in the timeout or a timeout that beats a simultaneous acknowledge. A peripheral model drives the data lines only while the read strobe is low, so capturing one edge late returns a marker value. The bench also sweeps the release lag and rest length, sends a `start` into an active cycle, and checks that the timeout flag stays set until it is cleared.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LATCH,
        ST_LATCH_GAP,
        ST_SEL_LEAD,
        ST_SEL_HOLD,
        ST_ACK_WAIT,
        ST_SETTLE,
        ST_RELEASE,
        ST_REST
    } rd_state_e;

endpackage

// File: rtl/pbus_ack_cond.sv
module pbus_ack_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_raw,
    input  logic direct,
    input  logic level,
    output logic ack_hit
);
    logic [SYNC_STAGES-1:0] chain;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= ack_raw;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    logic ack_lvl;
    always_comb begin
        ack_lvl = direct ? ack_raw : chain[SYNC_STAGES-1];
        ack_hit = (ack_lvl == level);
    end

endmodule

// File: rtl/pbus_phase_timer.sv
module pbus_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R2: between loads the interval counter only runs down
    p_timer_no_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt <= $past(cnt)));

endmodule

// File: rtl/pbus_wait_limit.sv
module pbus_wait_limit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] limit,
    input  logic         tick,
    output logic         expire
);
    logic [W-1:0] cnt;
    logic         armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (load) begin
            cnt   <= limit;
            armed <= (limit != '0);
        end else if (tick && cnt != '0) begin
            cnt   <= cnt - 1'b1;
        end
    end

    assign expire = armed && (cnt == {{(W-1){1'b0}}, 1'b1});

    // R11: a zero limit never produces an expiry
    p_zero_limit_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (load && limit == '0) |=> !expire);

endmodule

// File: rtl/pbus_ackrd_ctrl.sv
module pbus_ackrd_ctrl
    import pbus_pkg::*;
#(
    parameter int AD_W        = 32,
    parameter int PH_W        = 4,
    parameter int LAG_W       = 2,
    parameter int LIM_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AD_W-1:0]  addr,
    input  logic [PH_W-1:0]  cfg_latch_len,
    input  logic [PH_W-1:0]  cfg_latch_gap,
    input  logic [PH_W-1:0]  cfg_sel_lead,
    input  logic [PH_W-1:0]  cfg_sel_hold,
    input  logic [PH_W-1:0]  cfg_ack_delay,
    input  logic [LAG_W-1:0] cfg_release_lag,
    input  logic [PH_W-1:0]  cfg_rest_len,
    input  logic             cfg_ack_level,
    input  logic             cfg_ack_direct,
    input  logic [LIM_W-1:0] cfg_wait_limit,
    output logic             pb_ale,
    output logic             pb_sel_n,
    output logic             pb_rd_n,
    output logic [AD_W-1:0]  pb_ad_out,
    output logic             pb_ad_drive,
    input  logic [AD_W-1:0]  pb_ad_in,
    input  logic             pb_ack,
    output logic             busy,
    output logic             done,
    output logic [AD_W-1:0]  rd_data,
    output logic             rd_err,
    output logic             err_irq,
    output logic             tmo_flag,
    input  logic             tmo_flag_clr
);
    localparam logic [PH_W-1:0]  PH_ONE  = {{(PH_W-1){1'b0}}, 1'b1};
    localparam logic [LAG_W-1:0] LAG_ONE = {{(LAG_W-1){1'b0}}, 1'b1};

    rd_state_e st, nxt;

    // configuration captured at request acceptance
    logic [PH_W-1:0]  c_gap, c_lead, c_hold, c_delay, c_rest;
    logic [LAG_W-1:0] c_lag;
    logic             c_level, c_direct;
    logic [LIM_W-1:0] c_limit;
    logic [AD_W-1:0]  c_addr;

    logic            t_load, t_exp;
    logic [PH_W-1:0] t_val;
    logic            w_load, w_tick, w_exp;
    logic            ack_hit;
    logic            capture, abort;

    // state after the read strobe is released
    rd_state_e       tail_st,  rest_st;
    logic [PH_W-1:0] tail_val, rest_val;
    logic            tail_load, rest_load;

    pbus_ack_cond #(.SYNC_STAGES(SYNC_STAGES)) u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack_raw (pb_ack),
        .direct  (c_direct),
        .level   (c_level),
        .ack_hit (ack_hit)
    );

    pbus_phase_timer #(.W(PH_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    pbus_wait_limit #(.W(LIM_W)) u_limit (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (w_load),
        .limit  (c_limit),
        .tick   (w_tick),
        .expire (w_exp)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_gap    <= '0;
            c_lead   <= '0;
            c_hold   <= '0;
            c_delay  <= '0;
            c_rest   <= '0;
            c_lag    <= '0;
            c_level  <= 1'b1;
            c_direct <= 1'b0;
            c_limit  <= '0;
            c_addr   <= '0;
        end else if (st == ST_IDLE && start) begin
            c_gap    <= cfg_latch_gap;
            c_lead   <= cfg_sel_lead;
            c_hold   <= cfg_sel_hold;
            c_delay  <= cfg_ack_delay;
            c_rest   <= cfg_rest_len;
            c_lag    <= cfg_release_lag;
            c_level  <= cfg_ack_level;
            c_direct <= cfg_ack_direct;
            c_limit  <= cfg_wait_limit;
            c_addr   <= addr;
        end
    end

    always_comb begin
        rest_load = (c_rest != '0);
        rest_st   = rest_load ? ST_REST : ST_IDLE;
        rest_val  = c_rest - PH_ONE;
        if (c_lag != '0) begin
            tail_st   = ST_RELEASE;
            tail_load = 1'b1;
            tail_val  = {{(PH_W-LAG_W){1'b0}}, c_lag - LAG_ONE};
        end else begin
            tail_st   = rest_st;
            tail_load = rest_load;
            tail_val  = rest_val;
        end
    end

    // next-state process
    always_comb begin
        nxt     = st;
        t_load  = 1'b0;
        t_val   = '0;
        w_load  = 1'b0;
        capture = 1'b0;
        abort   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start) begin
                    nxt    = ST_LATCH;
                    t_load = 1'b1;
                    t_val  = cfg_latch_len;
                end
            end
            ST_LATCH: begin
                if (t_exp) begin
                    nxt    = ST_LATCH_GAP;
                    t_load = 1'b1;
                    t_val  = c_gap;
                end
            end
            ST_LATCH_GAP: begin
                if (t_exp) begin
                    nxt    = ST_SEL_LEAD;
                    t_load = 1'b1;
                    t_val  = c_lead;
                end
            end
            ST_SEL_LEAD: begin
                if (t_exp) begin
                    nxt    = ST_SEL_HOLD;
                    t_load = 1'b1;
                    t_val  = c_hold;
                end
            end
            ST_SEL_HOLD: begin
                if (t_exp) begin
                    nxt    = ST_ACK_WAIT;
                    w_load = 1'b1;
                end
            end
            ST_ACK_WAIT: begin
                if (ack_hit) begin
                    if (c_delay == '0) begin
                        capture = 1'b1;
                        nxt     = tail_st;
                        t_load  = tail_load;
                        t_val   = tail_val;
                    end else begin
                        nxt    = ST_SETTLE;
                        t_load = 1'b1;
                        t_val  = c_delay - PH_ONE;
                    end
                end else if (w_exp) begin
                    abort  = 1'b1;
                    nxt    = tail_st;
                    t_load = tail_load;
                    t_val  = tail_val;
                end
            end
            ST_SETTLE: begin
                if (t_exp) begin
                    capture = 1'b1;
                    nxt     = tail_st;
                    t_load  = tail_load;
                    t_val   = tail_val;
                end
            end
            ST_RELEASE: begin
                if (t_exp) begin
                    nxt    = rest_st;
                    t_load = rest_load;
                    t_val  = rest_val;
                end
            end
            ST_REST: begin
                if (t_exp) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign w_tick = (st == ST_ACK_WAIT) && !ack_hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // bus pin decode
    always_comb begin
        pb_ale      = 1'b0;
        pb_sel_n    = 1'b1;
        pb_rd_n     = 1'b1;
        pb_ad_drive = 1'b0;
        unique case (st)
            ST_LATCH: begin
                pb_ale      = 1'b1;
                pb_ad_drive = 1'b1;
            end
            ST_LATCH_GAP: pb_ad_drive = 1'b1;
            ST_SEL_LEAD:  pb_sel_n    = 1'b0;
            ST_SEL_HOLD, ST_ACK_WAIT, ST_SETTLE: begin
                pb_sel_n = 1'b0;
                pb_rd_n  = 1'b0;
            end
            ST_RELEASE:   pb_sel_n = 1'b0;
            default: ;
        endcase
    end

    assign pb_ad_out = c_addr;
    assign busy      = (st != ST_IDLE);

    // completion and status outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            rd_data  <= '0;
            rd_err   <= 1'b0;
            err_irq  <= 1'b0;
            tmo_flag <= 1'b0;
        end else begin
            done    <= capture || abort;
            err_irq <= abort;
            if (capture) begin
                rd_data <= pb_ad_in;
                rd_err  <= 1'b0;
            end else if (abort) begin
                rd_data <= '0;
                rd_err  <= 1'b1;
            end
            if (abort)             tmo_flag <= 1'b1;
            else if (tmo_flag_clr) tmo_flag <= 1'b0;
        end
    end

    // R7: completion is a single-cycle pulse
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: read strobe rises in the completion cycle
    p_rd_release_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pb_rd_n && !$past(pb_rd_n)));
    // R3: no driver contention on the shared lines
    p_ad_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pb_rd_n |-> !pb_ad_drive);
    // R10: interrupt only accompanies an erroring completion
    p_irq_with_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (done && rd_err));
    // R12: timeout flag is sticky until cleared
    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && !tmo_flag_clr) |=> tmo_flag);
    // R9: a new cycle starts only from IDLE
    p_start_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LATCH && $past(st) != ST_LATCH) |-> $past(st) == ST_IDLE);
    // R4: acknowledge is watched only with select and read strobe active
    p_wait_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACK_WAIT) |-> (!pb_sel_n && !pb_rd_n));

endmodule

// File: tb/sim_pbus_ackrd_ctrl.sv
`timescale 1ns/1ps
module sim_pbus_ackrd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] addr = '0;
    logic [3:0]  cfg_latch_len = '0, cfg_latch_gap = '0, cfg_sel_lead = '0;
    logic [3:0]  cfg_sel_hold = '0, cfg_ack_delay = '0, cfg_rest_len = '0;
    logic [1:0]  cfg_release_lag = '0;
    logic        cfg_ack_level = 1'b1, cfg_ack_direct = 1'b1;
    logic [7:0]  cfg_wait_limit = '0;
    logic        pb_ale, pb_sel_n, pb_rd_n, pb_ad_drive;
    logic [31:0] pb_ad_out, pb_ad_in, rd_data;
    logic        pb_ack = 1'b0;
    logic        busy, done, rd_err, err_irq, tmo_flag;
    logic        tmo_flag_clr = 1'b0;
    logic [31:0] pdata = '0;

    always #2.5 clk = ~clk;

    assign pb_ad_in = pb_rd_n ? 32'hDEAD_BEEF : pdata;

    pbus_ackrd_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr),
        .cfg_latch_len(cfg_latch_len), .cfg_latch_gap(cfg_latch_gap),
        .cfg_sel_lead(cfg_sel_lead), .cfg_sel_hold(cfg_sel_hold),
        .cfg_ack_delay(cfg_ack_delay), .cfg_release_lag(cfg_release_lag),
        .cfg_rest_len(cfg_rest_len), .cfg_ack_level(cfg_ack_level),
        .cfg_ack_direct(cfg_ack_direct), .cfg_wait_limit(cfg_wait_limit),
        .pb_ale(pb_ale), .pb_sel_n(pb_sel_n), .pb_rd_n(pb_rd_n),
        .pb_ad_out(pb_ad_out), .pb_ad_drive(pb_ad_drive), .pb_ad_in(pb_ad_in),
        .pb_ack(pb_ack), .busy(busy), .done(done), .rd_data(rd_data),
        .rd_err(rd_err), .err_irq(err_irq), .tmo_flag(tmo_flag),
        .tmo_flag_clr(tmo_flag_clr)
    );

    int n_chk = 0, n_fail = 0;
    int ecount = 0;

    // event record, by edge index
    int t_ale_rise, t_ale_fall, t_sel_fall, t_rd_fall, t_rd_rise, t_sel_rise;
    int t_busy_rise, t_busy_fall, t_done, t_irq;
    int ale_rises, done_hits, contention, addr_bad;
    logic [31:0] got_data, exp_addr;
    logic        got_err;
    logic p_ale = 0, p_sel_n = 1, p_rd_n = 1, p_busy = 0;

    task automatic clear_rec();
        t_ale_rise = -1; t_ale_fall = -1; t_sel_fall = -1; t_rd_fall = -1;
        t_rd_rise = -1; t_sel_rise = -1; t_busy_rise = -1; t_busy_fall = -1;
        t_done = -1; t_irq = -1;
        ale_rises = 0; done_hits = 0; contention = 0; addr_bad = 0;
        got_data = '0; got_err = 1'b0;
    endtask

    always @(posedge clk) begin
        ecount = ecount + 1;
        #1;
        if (pb_ale && !p_ale) begin ale_rises++; if (t_ale_rise < 0) t_ale_rise = ecount; end
        if (!pb_ale && p_ale && t_ale_fall < 0) t_ale_fall = ecount;
        if (!pb_sel_n && p_sel_n && t_sel_fall < 0) t_sel_fall = ecount;
        if (pb_sel_n && !p_sel_n && t_sel_rise < 0) t_sel_rise = ecount;
        if (!pb_rd_n && p_rd_n && t_rd_fall < 0) t_rd_fall = ecount;
        if (pb_rd_n && !p_rd_n && t_rd_rise < 0) t_rd_rise = ecount;
        if (busy && !p_busy && t_busy_rise < 0) t_busy_rise = ecount;
        if (!busy && p_busy && t_busy_fall < 0) t_busy_fall = ecount;
        if (pb_ale && (!pb_ad_drive || pb_ad_out !== exp_addr)) addr_bad++;
        if (pb_ad_drive && !pb_rd_n) contention++;
        if (done) begin
            done_hits++;
            if (t_done < 0) begin t_done = ecount; got_data = rd_data; got_err = rd_err; end
        end
        if (err_irq && t_irq < 0) t_irq = ecount;
        p_ale = pb_ale; p_sel_n = pb_sel_n; p_rd_n = pb_rd_n; p_busy = busy;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one read; ack_off places the acknowledge relative to the first wait cycle
    task automatic run_read(input int lat, input int gap, input int lead, input int hold,
                            input int dly, input int lag, input int rest,
                            input bit lvl, input bit direct, input int lim,
                            input bit no_ack, input int ack_off,
                            input logic [31:0] a, input logic [31:0] d,
                            input bit extra_start, input string tag);
        int s, w, r, k, exp_done, guard;
        bit exp_to;
        @(negedge clk);
        cfg_latch_len = 4'(lat); cfg_latch_gap = 4'(gap); cfg_sel_lead = 4'(lead);
        cfg_sel_hold = 4'(hold); cfg_ack_delay = 4'(dly); cfg_release_lag = 2'(lag);
        cfg_rest_len = 4'(rest); cfg_ack_level = lvl; cfg_ack_direct = direct;
        cfg_wait_limit = 8'(lim); addr = a; exp_addr = a; pdata = d;
        pb_ack = ~lvl;
        repeat (3) @(negedge clk);
        clear_rec();
        start = 1'b1; s = ecount + 1;
        @(negedge clk); start = 1'b0;
        w = s + lat + gap + lead + hold + 4;
        r = w + ack_off;
        if (no_ack) begin
            exp_to = 1'b1; exp_done = w + lim;
        end else begin
            k = direct ? r : r + 2;
            if (k < w + 1) k = w + 1;
            if (lim != 0 && k > w + lim) begin exp_to = 1'b1; exp_done = w + lim; end
            else begin exp_to = 1'b0; exp_done = k + dly; end
            while (ecount < r - 1) @(negedge clk);
            pb_ack = lvl;
        end
        guard = 0;
        while (t_done < 0 && guard < 3000) begin @(negedge clk); guard++; end
        pb_ack = ~lvl;
        if (extra_start) begin
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        guard = 0;
        while (t_busy_fall < 0 && guard < 100) begin @(negedge clk); guard++; end
        repeat (3) @(negedge clk);
        chk(t_ale_rise == s && t_busy_rise == s, {tag, " R2 latch start"}, t_ale_rise, s);
        chk(t_ale_fall == s + lat + 1, {tag, " R2 latch length"}, t_ale_fall, s + lat + 1);
        chk(t_sel_fall == s + lat + gap + 2, {tag, " R2 select assert"}, t_sel_fall, s + lat + gap + 2);
        chk(addr_bad == 0, {tag, " R2 address driven during latch"}, addr_bad, 0);
        chk(t_rd_fall == t_sel_fall + lead + 1, {tag, " R3 read strobe"}, t_rd_fall, t_sel_fall + lead + 1);
        chk(contention == 0, {tag, " R3 lines released"}, contention, 0);
        chk(t_done == exp_done, {tag, " R4/R5/R6/R10 completion time"}, t_done, exp_done);
        chk(done_hits == 1, {tag, " R7 single done"}, done_hits, 1);
        chk(t_rd_rise == t_done, {tag, " R7 strobe release"}, t_rd_rise, t_done);
        chk(t_sel_rise == t_done + lag, {tag, " R8 select release lag"}, t_sel_rise, t_done + lag);
        chk(t_busy_fall == t_done + lag + rest && !busy, {tag, " R9 busy end"}, t_busy_fall, t_done + lag + rest);
        chk(ale_rises == 1, {tag, " R9 single cycle"}, ale_rises, 1);
        if (exp_to) begin
            chk(got_err == 1'b1 && got_data == 32'h0, {tag, " R10 error data"}, got_data, 0);
            chk(t_irq == t_done, {tag, " R10 interrupt"}, t_irq, t_done);
            chk(tmo_flag == 1'b1, {tag, " R12 flag held"}, tmo_flag, 1);
        end else begin
            chk(got_err == 1'b0 && got_data == d, {tag, " R7 data"}, got_data, d);
            chk(t_irq == -1, {tag, " R10 no interrupt"}, t_irq, -1);
        end
    endtask

    task automatic t_reset();
        #1;
        chk(!pb_ale && pb_sel_n && pb_rd_n && !pb_ad_drive, "R1 bus idle", {pb_ale, pb_sel_n, pb_rd_n, pb_ad_drive}, 4'b0110);
        chk(!busy && !done && !err_irq && !tmo_flag, "R1 status idle", {busy, done, err_irq, tmo_flag}, 0);
    endtask

    task automatic t_direct();
        run_read(1, 0, 1, 2, 0, 1, 1, 1'b1, 1'b1, 20, 1'b0, 3, 32'h1234_5678, 32'hA5A5_0001, 1'b0, "R5 direct");
        run_read(0, 2, 0, 0, 3, 2, 0, 1'b1, 1'b1, 20, 1'b0, 1, 32'h0000_00F0, 32'h0BAD_F00D, 1'b0, "R7 settle");
    endtask

    task automatic t_synced();
        run_read(2, 1, 1, 1, 0, 0, 0, 1'b1, 1'b0, 30, 1'b0, 2, 32'hCAFE_0000, 32'h1111_2222, 1'b0, "R5 synced");
        run_read(0, 0, 0, 0, 2, 3, 2, 1'b1, 1'b0, 30, 1'b0, 0, 32'h0F0F_0F0F, 32'h3333_4444, 1'b0, "R5 synced settle");
    endtask

    task automatic t_polarity();
        run_read(1, 1, 1, 1, 1, 1, 1, 1'b0, 1'b1, 20, 1'b0, 2, 32'h8000_0001, 32'h5555_AAAA, 1'b0, "R6 active low");
        run_read(1, 1, 1, 1, 0, 0, 1, 1'b0, 1'b0, 20, 1'b0, 1, 32'h8000_0002, 32'h6666_7777, 1'b0, "R6 active low synced");
    endtask

    task automatic t_early_ack();
        run_read(0, 0, 1, 4, 0, 1, 0, 1'b1, 1'b1, 10, 1'b0, -5, 32'h0000_1000, 32'h7777_0000, 1'b0, "R4 early direct");
        run_read(0, 0, 1, 3, 1, 0, 0, 1'b1, 1'b0, 10, 1'b0, -4, 32'h0000_2000, 32'h7777_1111, 1'b0, "R4 early synced");
    endtask

    task automatic t_lag_sweep();
        for (int lg = 0; lg < 4; lg++)
            run_read(0, 0, 0, 0, 0, lg, (lg == 2) ? 0 : 2, 1'b1, 1'b1, 0, 1'b0, 1,
                     32'h4000_0000 + 32'(lg), 32'h9000_0000 + 32'(lg), 1'b0, "R8 lag sweep");
    endtask

    task automatic t_timeout();
        run_read(0, 0, 0, 1, 0, 1, 1, 1'b1, 1'b1, 5, 1'b1, 0, 32'h0000_0ABC, 32'h1, 1'b0, "R10 no ack");
        @(negedge clk); tmo_flag_clr = 1'b1;
        @(negedge clk); tmo_flag_clr = 1'b0;
        chk(tmo_flag == 1'b0, "R12 flag cleared", tmo_flag, 0);
    endtask

    task automatic t_limit_edge();
        // ack in last allowed wait cycle succeeds, one later aborts
        run_read(0, 0, 0, 0, 0, 0, 0, 1'b1, 1'b1, 4, 1'b0, 4, 32'h0000_0111, 32'hBEEF_0004, 1'b0, "R10 last cycle ok");
        run_read(0, 0, 0, 0, 0, 0, 0, 1'b1, 1'b1, 4, 1'b0, 5, 32'h0000_0222, 32'hBEEF_0005, 1'b0, "R10 one late");
        @(negedge clk); tmo_flag_clr = 1'b1;
        @(negedge clk); tmo_flag_clr = 1'b0;
        chk(tmo_flag == 1'b0, "R12 flag cleared again", tmo_flag, 0);
    endtask

    task automatic t_no_limit();
        run_read(0, 0, 0, 0, 0, 0, 0, 1'b1, 1'b1, 0, 1'b0, 300, 32'h0000_0333, 32'h2468_ACE0, 1'b0, "R11 unlimited wait");
        chk(tmo_flag == 1'b0, "R11 no timeout flag", tmo_flag, 0);
    endtask

    task automatic t_busy_start();
        run_read(0, 0, 0, 0, 0, 1, 3, 1'b1, 1'b1, 10, 1'b0, 1, 32'h0000_0444, 32'h1357_9BDF, 1'b1, "R9 start while busy");
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", ecount, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        exp_addr = '0;
        clear_rec();
        repeat (4) @(negedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_direct();
        t_synced();
        t_polarity();
        t_early_ack();
        t_lag_sweep();
        t_timeout();
        t_limit_edge();
        t_no_limit();
        t_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule